// File: doc/BRIEF.md
# Dual-Word Programmable Down-Counter Divider

This block divides its clock by a programmable ratio using an 8-bit down counter. Two program words each sit in their own holding latch. A latch is transparent while its load input is high, so software can stage a new word without touching the word the counter is using. When the counter reaches zero it reloads from one of the two words, and a select input picks which one. A loaded value N gives a division ratio of N+1.

A terminal-count flag goes high when the counter is at zero. It passes through a rising-edge register before it reaches the output. A clock enable stalls the counter and suppresses the flag. Alternating the select line between the two words gives a dual-modulus divider. An active-low asynchronous master reset clears the counter, presets both words to all ones and drives the terminal count high.

Top module: `dwd_divider`

## Requirements
- R1: While rst_ni is low, tc_o is 1, the counter is 0 and both program words are 8'hFF. With ce_i high and sel_i at 0 after release, the first tc_o pulse period is 256 cycles.
- R2: With ce_i held high and selected word N, tc_o rises once every N+1 clock cycles. For N=0, tc_o stays high.
- R3: For N>=1, each tc_o pulse lasts exactly one clock cycle. It is driven by a register and becomes high in the cycle that follows the edge at which the counter reloads.
- R4: sel_i=0 picks word A and sel_i=1 picks word B. sel_i is sampled only at the reload edge, so changing it in the middle of a count does not change the current period.
- R5: While ce_i is low, the counter holds its value and tc_o is 0. After ce_i returns high, counting continues from the held value.
- R6: A word latch follows its data input while its load input is high and holds when the load input is low. A new word first takes effect at the reload after the next terminal count, and the count in progress is not disturbed.
- R7: Word bit 7 is the MSB, so word 8'h80 gives a period of 129.
- R8: On the first enabled clock edge after reset is released, the counter reloads from the selected word and tc_o stays high for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock, rising edge |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| ce_i | input | 1 | Count enable |
| sel_i | input | 1 | Word select at reload: 0 = word A, 1 = word B |
| load_a_i | input | 1 | Word A latch transparent while high |
| load_b_i | input | 1 | Word B latch transparent while high |
| word_a_i | input | 8 | Word A data, bit 7 MSB |
| word_b_i | input | 8 | Word B data, bit 7 MSB |
| tc_o | output | 1 | Registered terminal count |

## Verification
The case that is hardest to reach from the ports is a word or select change that lands partway through a count, because the bench can only see the counter's position through tc_o. The stimulus therefore synchronises to a tc_o pulse, which marks the cycle in which the counter holds its fresh word. It then waits a known number of cycles before reprogramming a latch or toggling sel_i. Next it measures the period in progress and the period after it, expecting the old ratio first and the new ratio second. The clock-enable stall is placed at that same known position, so the expected number of cycles left after re-enabling is known.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  localparam int unsigned WORD_W = 8;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dwd_word_latch.sv
module dwd_word_latch #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // Transparent while load_i is high; reset presets to all ones.
  always_latch begin
    if (!rst_ni)     q_o <= '1;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/dwd_down_counter.sv
module dwd_down_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic [W-1:0] reload_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;
  logic         tc_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign tc_o    = tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= 1'b1;
    end else begin
      if (ce_i) cnt_q <= at_zero ? reload_i : cnt_q - W'(1);
      tc_q <= ce_i & at_zero;
    end
  end

  // R5
  hold_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(cnt_q) && !tc_o);

  // R2
  reload_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)) && tc_o);

  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && cnt_q != '0) |=> !tc_o && (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/dwd_divider.sv
module dwd_divider
  import dwd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_i,
  input  logic        sel_i,
  input  logic        load_a_i,
  input  logic        load_b_i,
  input  logic [7:0]  word_a_i,
  input  logic [7:0]  word_b_i,
  output logic        tc_o
);
  localparam int unsigned NWORDS = 2;

  logic  [NWORDS-1:0] load_v;
  word_t              d_v [NWORDS];
  word_t              q_v [NWORDS];
  word_t              reload_word;

  assign load_v = {load_b_i, load_a_i};
  assign d_v[0] = word_a_i;
  assign d_v[1] = word_b_i;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    dwd_word_latch #(.W(WORD_W)) i_latch (
      .rst_ni (rst_ni),
      .load_i (load_v[g]),
      .d_i    (d_v[g]),
      .q_o    (q_v[g])
    );
  end

  // Only read by the counter at the reload edge.
  assign reload_word = sel_i ? q_v[1] : q_v[0];

  dwd_down_counter #(.W(WORD_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_i     (ce_i),
    .reload_i (reload_word),
    .tc_o     (tc_o)
  );

  // R6
  word_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_a_i ##1 !load_a_i) |-> $stable(q_v[0]));
  // R6
  word_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_b_i ##1 !load_b_i) |-> $stable(q_v[1]));
endmodule

// File: tb/test_dwd_divider.sv
module test_dwd_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, sel = 1'b0, ld_a = 1'b0, ld_b = 1'b0;
  logic [7:0] wa = '0, wb = '0;
  logic       tc;
  int         checks = 0, fails = 0, cyc = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dwd_divider i_dwd_divider (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sel_i(sel),
    .load_a_i(ld_a), .load_b_i(ld_b), .word_a_i(wa), .word_b_i(wb), .tc_o(tc)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Negedges until tc is high; called from a negedge.
  task automatic wait_tc(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tc && n < 1000);
  endtask

  task automatic load_a(input logic [7:0] v);
    wa = v; ld_a = 1'b1; @(negedge clk); ld_a = 1'b0; wa = ~v;
  endtask
  task automatic load_b(input logic [7:0] v);
    wb = v; ld_b = 1'b1; @(negedge clk); ld_b = 1'b0; wb = ~v;
  endtask

  // At a tc negedge with the word under test just reloaded.
  task automatic measure(input string req, input int n);
    int p;
    @(negedge clk);
    if (n > 0) chk("R3", int'(tc), 0);
    if (n == 0) p = 1;
    else begin
      wait_tc(p);
      p = p + 1;
    end
    chk(req, p, n + 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    chk("R1", int'(tc), 1);
    // R1 / R8: reset release, first enabled edge reloads 8'hFF.
    ce = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", int'(tc), 1);
    measure("R1", 255);

    // R2 / R4: sweep both words.
    for (int n = 0; n < 256; n++) begin
      if (n < 16 || n > 247 || n % 17 == 0) begin
        load_a(8'(n));
        load_b(8'(255 - n));
        sel = 1'b0;
        wait_tc(p);
        wait_tc(p);
        measure("R2", n);
        sel = 1'b1;
        wait_tc(p);
        wait_tc(p);
        measure("R4", 255 - n);
      end
    end

    // R7: MSB position.
    load_a(8'h80);
    sel = 1'b0;
    wait_tc(p);
    wait_tc(p);
    measure("R7", 128);

    // R4: alternating select at each terminal count.
    load_a(8'd2);
    load_b(8'd5);
    sel = 1'b0;
    wait_tc(p);
    wait_tc(p);
    for (int k = 0; k < 4; k++) begin
      sel = ~sel;
      wait_tc(p);
      chk("R4", p, sel ? 3 : 6);
    end

    // R4: mid-count select glitch does not change the period.
    load_a(8'd10);
    sel = 1'b0;
    wait_tc(p);
    wait_tc(p);
    @(negedge clk); sel = 1'b1;
    @(negedge clk); sel = 1'b0;
    wait_tc(p);
    chk("R4", p + 2, 11);

    // R6: mid-count reprogram of word A.
    load_a(8'd20);
    wait_tc(p);
    wait_tc(p);
    repeat (2) @(negedge clk);
    load_a(8'd4);
    wait_tc(p);
    chk("R6", p + 3, 21);
    wait_tc(p);
    chk("R6", p, 5);
    // R6: data change with load low is ignored.
    wa = 8'd50;
    wait_tc(p);
    chk("R6", p, 5);

    // R5: stall with clock enable low.
    load_a(8'd7);
    wait_tc(p);
    wait_tc(p);
    ce = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R5", int'(tc), 0);
    end
    ce = 1'b1;
    wait_tc(p);
    chk("R5", p, 8);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule